// File: doc/BRIEF.md
# Sign-Magnitude Add/Subtract Unit

This unit adds or subtracts two numbers kept in sign-magnitude form. Each operand has an unsigned magnitude of `MAG_W` bits and a separate sign bit (1 means negative). A one-bit operation input selects addition or subtraction. The result has the same form and adds an overflow flag. A single `MAG_W+1`-bit adder does all the arithmetic. When the effective signs differ, the adder forms |A| + ~|B| + 1. Its end carry then gives the magnitude comparison, and it tells the unit whether the difference must be re-complemented.

Operands enter on a valid/ready stream and the result leaves on a second valid/ready stream. A transfer takes place on any clock edge where both valid and ready are high. With `OUT_REG=1` (the default), a one-entry register sits at the output. While it holds a result that has not been taken, `in_ready` is low. A new operand pair can enter in the same cycle that the held result is taken, so full throughput is kept. With `OUT_REG=0` the path is combinational: `in_ready` follows `out_ready` and `out_valid` follows `in_valid`. Back-pressure therefore passes straight through to the producer.

Top module: `sm_addsub`

## Requirements
- R1: With `op_sub`=1 the sign of B is inverted before the rules of R2 to R7 are applied. With `op_sub`=0 the sign of B is used unchanged.
- R2: When the effective signs are equal, the result magnitude is the low `MAG_W` bits of |A|+|B|, and the result sign equals `a_sign`.
- R3: When the effective signs differ and |A| > |B|, the result magnitude is |A|−|B| and the sign is `a_sign`.
- R4: When the effective signs differ and |A| < |B|, the result magnitude is |B|−|A| and the sign is the effective sign of B.
- R5: When the effective signs differ and |A| = |B|, the result is magnitude 0 with sign 0 (positive zero).
- R6: With equal effective signs, `res_ovf` is 1 exactly when |A|+|B| ≥ 2^`MAG_W`.
- R7: With differing effective signs, `res_ovf` is always 0.
- R8: While `rst_n` is low and after it is released, `out_valid` is 0 until the first operand pair has been accepted.
- R9: With `OUT_REG=1`, while `out_valid`=1 and `out_ready`=0 the result outputs hold steady and `in_ready` is 0. The held result is replaced only after a transfer has taken it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Unit can accept an operand pair |
| op_sub | input | 1 | 0 = A+B, 1 = A−B |
| a_sign | input | 1 | Sign of A, 1 = negative |
| a_mag | input | MAG_W | Magnitude of A |
| b_sign | input | 1 | Sign of B, 1 = negative |
| b_mag | input | MAG_W | Magnitude of B |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer accepts the result |
| res_sign | output | 1 | Result sign, 1 = negative |
| res_mag | output | MAG_W | Result magnitude |
| res_ovf | output | 1 | Magnitude overflow of a like-sign addition |

## Verification
The assertions on the arithmetic are checked only in cycles where `in_valid` is high, because operand pins are taken to be undefined at other times. The stall assertion assumes the consumer keeps `out_ready` driven from reset onward. The bench drives every operand and ready pin to known values before reset is released. It presents operands only with `in_valid` high, and it holds them steady until they are accepted. A 4-bit configuration lets the sweep cover every magnitude pair under both signs and both operations, which includes every equal-magnitude case.

// File: rtl/sm_pkg.sv
package sm_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } sm_op_e;
endpackage

// File: rtl/sm_sign_resolve.sv
module sm_sign_resolve
  import sm_pkg::*;
(
  input  sm_op_e op,
  input  logic   a_sign,
  input  logic   b_sign,
  output logic   b_sign_eff,
  output logic   signs_differ
);
  // subtraction flips the sign of B, then the add rules apply
  always_comb begin
    b_sign_eff   = (op == OP_SUB) ? ~b_sign : b_sign;
    signs_differ = a_sign ^ b_sign_eff;
  end
endmodule

// File: rtl/sm_mag_unit.sv
module sm_mag_unit #(
  parameter int MAG_W = 8
) (
  input  logic [MAG_W-1:0] a_mag,
  input  logic [MAG_W-1:0] b_mag,
  input  logic             sub_mode,
  output logic [MAG_W-1:0] mag,
  output logic             a_ge_b,
  output logic             ovf
);
  localparam int SUM_W = MAG_W + 1;

  logic [MAG_W-1:0] b_term;
  logic [SUM_W-1:0] sum;
  logic             carry;

  always_comb begin
    // one adder: plain add, or A + ~B + 1 for magnitude subtraction
    b_term = sub_mode ? ~b_mag : b_mag;
    sum    = {1'b0, a_mag} + {1'b0, b_term} + {{MAG_W{1'b0}}, sub_mode};
    carry  = sum[SUM_W-1];
    a_ge_b = carry;
    if (sub_mode && !carry) begin
      mag = ~sum[MAG_W-1:0] + {{(MAG_W-1){1'b0}}, 1'b1};
    end else begin
      mag = sum[MAG_W-1:0];
    end
    ovf = !sub_mode && carry;
  end
endmodule

// File: rtl/sm_out_stage.sv
module sm_out_stage #(
  parameter int DATA_W  = 10,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  generate
    if (OUT_REG) begin : g_reg
      logic              vld_q;
      logic [DATA_W-1:0] dat_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
        end else if (in_ready) begin
          vld_q <= in_valid;
        end
      end

      always_ff @(posedge clk) begin
        if (in_ready && in_valid) begin
          dat_q <= in_data;
        end
      end

      assign in_ready  = !vld_q || out_ready;
      assign out_valid = vld_q;
      assign out_data  = dat_q;

      AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9
      AST_NO_ACCEPT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready); // R9
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate
endmodule

// File: rtl/sm_addsub.sv
module sm_addsub
  import sm_pkg::*;
#(
  parameter int MAG_W   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             op_sub,
  input  logic             a_sign,
  input  logic [MAG_W-1:0] a_mag,
  input  logic             b_sign,
  input  logic [MAG_W-1:0] b_mag,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             res_sign,
  output logic [MAG_W-1:0] res_mag,
  output logic             res_ovf
);
  localparam int PAY_W = MAG_W + 2;

  logic             b_sign_eff;
  logic             signs_differ;
  logic [MAG_W-1:0] mag_c;
  logic             a_ge_b;
  logic             ovf_c;
  logic             sign_c;
  logic             mag_zero;
  logic [PAY_W-1:0] pay_in;
  logic [PAY_W-1:0] pay_out;

  sm_sign_resolve u_sign (
    .op           (sm_op_e'(op_sub)),
    .a_sign       (a_sign),
    .b_sign       (b_sign),
    .b_sign_eff   (b_sign_eff),
    .signs_differ (signs_differ)
  );

  sm_mag_unit #(.MAG_W(MAG_W)) u_mag (
    .a_mag    (a_mag),
    .b_mag    (b_mag),
    .sub_mode (signs_differ),
    .mag      (mag_c),
    .a_ge_b   (a_ge_b),
    .ovf      (ovf_c)
  );

  always_comb begin
    mag_zero = (mag_c == '0);
    if (!signs_differ)  sign_c = a_sign;
    else if (mag_zero)  sign_c = 1'b0;
    else if (a_ge_b)    sign_c = a_sign;
    else                sign_c = b_sign_eff;
    pay_in = {sign_c, ovf_c, mag_c};
  end

  sm_out_stage #(.DATA_W(PAY_W), .OUT_REG(OUT_REG)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign res_sign = pay_out[PAY_W-1];
  assign res_ovf  = pay_out[PAY_W-2];
  assign res_mag  = pay_out[MAG_W-1:0];

  AST_LIKE_SIGN_A: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !signs_differ) |-> (sign_c == a_sign)); // R2
  AST_DIFF_MAG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && signs_differ) |-> (mag_c <= a_mag || mag_c <= b_mag)); // R3
  AST_POS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && signs_differ && a_mag == b_mag) |-> (mag_c == '0 && !sign_c)); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && signs_differ) |-> !ovf_c); // R7
endmodule

// File: tb/sm_addsub_tb.sv
module sm_addsub_tb;
  localparam int W = 4;
  localparam int M = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic op_sub = 1'b0, a_sign = 1'b0, b_sign = 1'b0;
  logic [W-1:0] a_mag = '0, b_mag = '0;
  logic out_valid, out_ready = 1'b1;
  logic res_sign, res_ovf;
  logic [W-1:0] res_mag;

  int n_tests = 0;
  int n_fail  = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sm_addsub #(.MAG_W(W), .OUT_REG(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_sub(op_sub), .a_sign(a_sign), .a_mag(a_mag), .b_sign(b_sign),
    .b_mag(b_mag), .out_valid(out_valid), .out_ready(out_ready),
    .res_sign(res_sign), .res_mag(res_mag), .res_ovf(res_ovf)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void expect_of(input bit op, input bit sa, input int am,
                                    input bit sb, input int bm,
                                    output bit es, output int em, output bit eo,
                                    output string req);
    bit sbe;
    sbe = op ? ~sb : sb; // R1
    eo = 1'b0;
    if (sa == sbe) begin
      em = (am + bm) % M; es = sa; eo = ((am + bm) >= M); req = "R2/R6";
    end else if (am > bm) begin
      em = am - bm; es = sa; req = "R3/R7";
    end else if (am < bm) begin
      em = bm - am; es = sbe; req = "R4/R7";
    end else begin
      em = 0; es = 1'b0; req = "R5/R7";
    end
    if (op) req = {req, "/R1"};
  endfunction

  task automatic drive(input bit op, input bit sa, input int am, input bit sb, input int bm);
    op_sub = op; a_sign = sa; a_mag = W'(am); b_sign = sb; b_mag = W'(bm);
    in_valid = 1'b1;
  endtask

  task automatic check_out(input bit op, input bit sa, input int am, input bit sb, input int bm);
    bit es, eo; int em; string req;
    expect_of(op, sa, am, sb, bm, es, em, eo, req);
    chk({req, " valid"}, int'(out_valid), 1);
    chk({req, " mag"},   int'(res_mag),   em);
    chk({req, " sign"},  int'(res_sign),  int'(es));
    chk({req, " ovf"},   int'(res_ovf),   int'(eo));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset out_valid", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 after reset out_valid", int'(out_valid), 0);

    // exhaustive sweep of the 4-bit configuration
    for (int op = 0; op < 2; op++)
      for (int sa = 0; sa < 2; sa++)
        for (int sb = 0; sb < 2; sb++)
          for (int am = 0; am < M; am++)
            for (int bm = 0; bm < M; bm++) begin
              drive(op[0], sa[0], am, sb[0], bm);
              @(negedge clk);
              in_valid = 1'b0;
              check_out(op[0], sa[0], am, sb[0], bm);
              @(negedge clk);
            end
    chk("R8 idle out_valid", int'(out_valid), 0);

    // R9 back-pressure: X then Y while consumer stalls
    out_ready = 1'b0;
    drive(1'b0, 1'b1, 9, 1'b0, 4);
    @(negedge clk);
    check_out(1'b0, 1'b1, 9, 1'b0, 4);
    chk("R9 in_ready stall", int'(in_ready), 0);
    drive(1'b1, 1'b0, 3, 1'b0, 12);
    @(negedge clk);
    check_out(1'b0, 1'b1, 9, 1'b0, 4);
    chk("R9 in_ready still stalled", int'(in_ready), 0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_out(1'b1, 1'b0, 3, 1'b0, 12);
    @(negedge clk);
    chk("R9 drained out_valid", int'(out_valid), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule